// File: doc/BRIEF.md
# Two-Level Extended Opcode Dispatcher

This block sits behind an instruction decoder and receives the 8-bit secondary opcode that follows an escape opcode. It splits the 256 secondary opcodes into 16 groups of 16. It first checks whether the group is enabled. Only then does it check whether the individual opcode is implemented. One clock after an opcode-valid strobe, it issues either a handler-start pulse carrying the handler index or a trap pulse carrying a trap code. It never issues both.

A trap is raised when the group is missing, when the opcode is unimplemented, or when a running handler asks for a conditional trap. The trap code depends on two inputs and on the opcode group. One input selects the native or the alternate execution mode. The other says whether a trap table is present. The opcode that caused the trap is latched on a separate output.

Both maps load from a small configuration write port, indexed by group. When a handler finishes without pushing a result, the block emits a one-cycle stack-pointer decrement pulse. This undoes the push slot that was reserved before dispatch.

Top module: `xop_dispatch`

## Requirements
- R1: After reset, exactly groups 0x0, 0x1, 0x3, 0x4, 0x6 and 0xA are enabled (group = op_code[7:4]). All other groups are disabled.
- R2: After reset, the opcodes 0x02, 0x04, 0x0C, 0x0D, 0x0F, 0xA8, 0x41, 0x43 and 0x45 through 0x4F are marked unimplemented. Every other opcode in an enabled group is implemented (member = op_code[3:0]).
- R3: When op_valid is sampled high and the opcode is implemented in an enabled group, handler_start is high for exactly the next cycle and handler_idx equals the opcode. handler_start and trap_valid are never high together, and neither is high unless the previous cycle had a request.
- R4: An opcode in a disabled group ignores the member map and traps through the shared squash entry. trap_opcode reads 0xFF, and the trap code is the one that opcode 0xFF would get.
- R5: In native mode (mode_alt=0), a trap whose reported opcode lies in group 0x1 (the floating-point group) has trap_code 0x5F, and trap_opcode holds the offending opcode.
- R6: In native mode, a trap for any other group has trap_code 0x10.
- R7: In alternate mode (mode_alt=1), a trap has trap_code 0x11 when trap_tbl_present=1 and 0x12 when it is 0, in every group.
- R8: hdl_trap raises a trap in the next cycle, using the opcode of the last accepted dispatch for both the code and trap_opcode. It has priority over a simultaneous op_valid, which is dropped without a handler start.
- R9: sp_dec pulses for one cycle, one cycle after hdl_done is sampled high with hdl_pushed low. Otherwise it stays low.
- R10: A write with cfg_sel=0 sets the enable of group cfg_group to cfg_data[0]. A write with cfg_sel=1 replaces that group's implemented mask with cfg_data (bit i = member i). An opcode presented in the same cycle as a write is still decoded with the old maps.
- R11: trap_opcode and trap_code keep their values until the next trap. After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Secondary opcode strobe |
| op_code | input | 8 | Secondary opcode |
| mode_alt | input | 1 | 1 selects the alternate execution mode |
| trap_tbl_present | input | 1 | Trap table installed (alternate mode) |
| hdl_trap | input | 1 | Conditional trap request from the running handler |
| hdl_done | input | 1 | Handler finished |
| hdl_pushed | input | 1 | Finished handler pushed a result |
| cfg_we | input | 1 | Map write strobe |
| cfg_sel | input | 1 | 0 = group enable, 1 = member mask |
| cfg_group | input | 4 | Group written |
| cfg_data | input | 16 | Write data |
| handler_start | output | 1 | Handler start pulse |
| handler_idx | output | 8 | Handler index (the opcode) |
| trap_valid | output | 1 | Trap pulse |
| trap_code | output | 8 | Trap code |
| trap_opcode | output | 8 | Opcode reported with the last trap |
| sp_dec | output | 1 | Stack-pointer decrement pulse |

## Verification
The bench sweeps all 256 opcodes against the reset maps. A design that ignored the group level would start handlers for members of disabled groups, or report their own opcode instead of 0xFF. The bench disables the floating-point group and checks that its opcodes then squash with a non-float code. A design that chose the code from the raw opcode rather than the squash entry would wrongly return 0x5F. A handler trap is raised in the same cycle as a new opcode to catch a wrong priority, and a map write is raised in the same cycle as an opcode to catch a write that takes effect one cycle early. Random opcodes, modes and map writes are then compared against a bench model.

// File: rtl/xop_pkg.sv
package xop_pkg;

   typedef enum logic [7:0] {
      TC_NATIVE    = 8'h10,
      TC_ALT_TABLE = 8'h11,
      TC_ALT_STD   = 8'h12,
      TC_FLOAT     = 8'h5F
   } trap_code_e;

   typedef enum logic {
      CFG_GROUP  = 1'b0,
      CFG_MEMBER = 1'b1
   } cfg_sel_e;

   // Groups that come out of reset enabled.
   function automatic logic reset_group_on(input int g);
      return (g == 0) || (g == 1) || (g == 3) || (g == 4) || (g == 6) || (g == 10);
   endfunction

   // Implemented bit of member m in group g after reset.
   function automatic logic reset_member_on(input int g, input int m);
      case (g)
         0:       return !((m == 2) || (m == 4) || (m == 12) || (m == 13) || (m == 15));
         4:       return (m == 0) || (m == 2) || (m == 4);
         10:      return (m != 8);
         default: return 1'b1;
      endcase
   endfunction

endpackage

// File: rtl/xop_group_map.sv
module xop_group_map #(
   parameter int unsigned NGRP     = 16,
   parameter int unsigned GRP_W    = 4,
   parameter bit          WRITABLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [GRP_W-1:0] wr_grp,
   input  logic             wr_bit,
   output logic [NGRP-1:0]  grp_en
);

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      if (WRITABLE) begin : g_rw
         always_ff @(posedge clk) begin
            if (!rst_n)
               grp_en[g] <= xop_pkg::reset_group_on(g);
            else if (wr_en && (wr_grp == GRP_W'(g)))
               grp_en[g] <= wr_bit;
         end
      end else begin : g_ro
         assign grp_en[g] = xop_pkg::reset_group_on(g);
      end
   end

   if (!WRITABLE) begin : g_unused
      logic unused_inputs;
      assign unused_inputs = ^{clk, rst_n, wr_en, wr_grp, wr_bit};
   end

endmodule

// File: rtl/xop_member_map.sv
module xop_member_map #(
   parameter int unsigned NGRP     = 16,
   parameter int unsigned NMEM     = 16,
   parameter int unsigned GRP_W    = 4,
   parameter int unsigned CFG_W    = 16,
   parameter bit          WRITABLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [GRP_W-1:0] wr_grp,
   input  logic [CFG_W-1:0] wr_data,
   input  logic [GRP_W-1:0] rd_grp,
   output logic [NMEM-1:0]  rd_row
);

   function automatic logic [NMEM-1:0] rst_row(input int g);
      logic [NMEM-1:0] r;
      for (int m = 0; m < NMEM; m++) r[m] = xop_pkg::reset_member_on(g, m);
      return r;
   endfunction

   logic [NMEM-1:0] row_q [NGRP];

   for (genvar g = 0; g < NGRP; g++) begin : g_row
      if (WRITABLE) begin : g_rw
         always_ff @(posedge clk) begin
            if (!rst_n)
               row_q[g] <= rst_row(g);
            else if (wr_en && (wr_grp == GRP_W'(g)))
               row_q[g] <= wr_data[NMEM-1:0];
         end
      end else begin : g_ro
         assign row_q[g] = rst_row(g);
      end
   end

   assign rd_row = row_q[rd_grp];

   if (!WRITABLE) begin : g_unused_ro
      logic unused_inputs;
      assign unused_inputs = ^{clk, rst_n, wr_en, wr_grp, wr_data};
   end else if (CFG_W > NMEM) begin : g_unused_hi
      logic unused_hi;
      assign unused_hi = ^wr_data[CFG_W-1:NMEM];
   end

endmodule

// File: rtl/xop_trap_sel.sv
module xop_trap_sel #(
   parameter int unsigned OP_W     = 8,
   parameter int unsigned MEM_W    = 4,
   parameter int unsigned FP_GROUP = 1
) (
   input  logic [OP_W-1:0] src_op,
   input  logic            mode_alt,
   input  logic            tbl_present,
   output logic [7:0]      code
);
   localparam int unsigned GRP_W = OP_W - MEM_W;

   logic in_fp;
   assign in_fp = (src_op[OP_W-1:MEM_W] == GRP_W'(FP_GROUP));

   always_comb begin
      if (mode_alt)
         code = tbl_present ? xop_pkg::TC_ALT_TABLE : xop_pkg::TC_ALT_STD;
      else if (in_fp)
         code = xop_pkg::TC_FLOAT;
      else
         code = xop_pkg::TC_NATIVE;
   end

endmodule

// File: rtl/xop_dispatch.sv
module xop_dispatch #(
   parameter int unsigned OP_W     = 8,
   parameter int unsigned MEM_W    = 4,
   parameter int unsigned CFG_W    = 16,
   parameter int unsigned FP_GROUP = 1,
   parameter bit          WRITABLE = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  op_valid,
   input  logic [OP_W-1:0]       op_code,
   input  logic                  mode_alt,
   input  logic                  trap_tbl_present,
   input  logic                  hdl_trap,
   input  logic                  hdl_done,
   input  logic                  hdl_pushed,
   input  logic                  cfg_we,
   input  logic                  cfg_sel,
   input  logic [OP_W-MEM_W-1:0] cfg_group,
   input  logic [CFG_W-1:0]      cfg_data,
   output logic                  handler_start,
   output logic [OP_W-1:0]       handler_idx,
   output logic                  trap_valid,
   output logic [7:0]            trap_code,
   output logic [OP_W-1:0]       trap_opcode,
   output logic                  sp_dec
);
   localparam int unsigned GRP_W = OP_W - MEM_W;
   localparam int unsigned NGRP  = 1 << GRP_W;
   localparam int unsigned NMEM  = 1 << MEM_W;
   localparam logic [OP_W-1:0] SQUASH_OP = '1;

   if (MEM_W >= OP_W) begin : g_bad_split
      $error("member field must be narrower than the opcode");
   end
   if (CFG_W < NMEM) begin : g_bad_cfg
      $error("config data narrower than a member mask");
   end
   if (FP_GROUP >= NGRP) begin : g_bad_fp
      $error("floating-point group out of range");
   end

   logic [GRP_W-1:0] op_grp;
   logic [MEM_W-1:0] op_mem;
   logic [NGRP-1:0]  grp_en;
   logic [NMEM-1:0]  mem_row;
   logic             grp_hit, mem_hit;
   logic [OP_W-1:0]  cur_op;
   logic [OP_W-1:0]  trap_src;
   logic [7:0]       code_c;
   logic             wr_grp_en, wr_mem_en;

   assign op_grp    = op_code[OP_W-1:MEM_W];
   assign op_mem    = op_code[MEM_W-1:0];
   assign wr_grp_en = cfg_we && (cfg_sel == xop_pkg::CFG_GROUP);
   assign wr_mem_en = cfg_we && (cfg_sel == xop_pkg::CFG_MEMBER);

   xop_group_map #(.NGRP(NGRP), .GRP_W(GRP_W), .WRITABLE(WRITABLE)) u_grp (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_grp_en),
      .wr_grp (cfg_group),
      .wr_bit (cfg_data[0]),
      .grp_en (grp_en)
   );

   xop_member_map #(.NGRP(NGRP), .NMEM(NMEM), .GRP_W(GRP_W), .CFG_W(CFG_W),
                    .WRITABLE(WRITABLE)) u_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_mem_en),
      .wr_grp  (cfg_group),
      .wr_data (cfg_data),
      .rd_grp  (op_grp),
      .rd_row  (mem_row)
   );

   // Level one: group enable; level two only counts when level one passes.
   assign grp_hit = grp_en[op_grp];
   assign mem_hit = grp_hit && mem_row[op_mem];

   always_comb begin
      if (hdl_trap)      trap_src = cur_op;
      else if (grp_hit)  trap_src = op_code;
      else               trap_src = SQUASH_OP;
   end

   xop_trap_sel #(.OP_W(OP_W), .MEM_W(MEM_W), .FP_GROUP(FP_GROUP)) u_tsel (
      .src_op      (trap_src),
      .mode_alt    (mode_alt),
      .tbl_present (trap_tbl_present),
      .code        (code_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         handler_start <= 1'b0;
         handler_idx   <= '0;
         trap_valid    <= 1'b0;
         trap_code     <= '0;
         trap_opcode   <= '0;
         sp_dec        <= 1'b0;
         cur_op        <= '0;
      end else begin
         handler_start <= 1'b0;
         trap_valid    <= 1'b0;
         sp_dec        <= hdl_done && !hdl_pushed;
         if (hdl_trap) begin
            trap_valid  <= 1'b1;
            trap_code   <= code_c;
            trap_opcode <= trap_src;
         end else if (op_valid) begin
            cur_op <= op_code;
            if (mem_hit) begin
               handler_start <= 1'b1;
               handler_idx   <= op_code;
            end else begin
               trap_valid  <= 1'b1;
               trap_code   <= code_c;
               trap_opcode <= trap_src;
            end
         end
      end
   end

endmodule

// File: rtl/xop_dispatch_chk.sv
module xop_dispatch_chk #(
   parameter int unsigned OP_W = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            op_valid,
   input logic [OP_W-1:0] op_code,
   input logic            mode_alt,
   input logic            trap_tbl_present,
   input logic            hdl_trap,
   input logic            hdl_done,
   input logic            hdl_pushed,
   input logic            handler_start,
   input logic [OP_W-1:0] handler_idx,
   input logic            trap_valid,
   input logic [7:0]      trap_code,
   input logic [OP_W-1:0] trap_opcode,
   input logic            sp_dec
);

   p_one_outcome_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(handler_start && trap_valid));

   p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(op_valid || hdl_trap) |-> (!handler_start && !trap_valid));

   p_idx_r3: assert property (@(posedge clk) disable iff (!rst_n)
      handler_start |-> (handler_idx == $past(op_code)));

   p_priority_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(hdl_trap) |-> (trap_valid && !handler_start));

   p_float_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid && !$past(mode_alt) && (trap_opcode[OP_W-1:OP_W-4] == 4'h1))
      |-> (trap_code == xop_pkg::TC_FLOAT));

   p_alt_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid && $past(mode_alt))
      |-> (trap_code == ($past(trap_tbl_present) ? xop_pkg::TC_ALT_TABLE : xop_pkg::TC_ALT_STD)));

   p_sp_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sp_dec |-> $past(hdl_done && !hdl_pushed));

   p_sp_fire_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(hdl_done && !hdl_pushed) |-> sp_dec);

   p_topc_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_valid |-> ($stable(trap_opcode) && $stable(trap_code)));

endmodule

bind xop_dispatch xop_dispatch_chk #(.OP_W(OP_W)) u_chk (.*);

// File: tb/xop_dispatch_tb.sv
`timescale 1ns/1ps
module xop_dispatch_tb;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic op_valid = 1'b0;
   logic [7:0] op_code = '0;
   logic mode_alt = 1'b0;
   logic trap_tbl_present = 1'b0;
   logic hdl_trap = 1'b0;
   logic hdl_done = 1'b0;
   logic hdl_pushed = 1'b0;
   logic cfg_we = 1'b0;
   logic cfg_sel = 1'b0;
   logic [3:0] cfg_group = '0;
   logic [15:0] cfg_data = '0;
   logic handler_start;
   logic [7:0] handler_idx;
   logic trap_valid;
   logic [7:0] trap_code;
   logic [7:0] trap_opcode;
   logic sp_dec;

   always #2 clk = ~clk;

   xop_dispatch u_dut (.*);

   int checks = 0;
   int bad = 0;
   bit done = 1'b0;

   // Bench model of the maps and held outputs.
   logic [15:0] m_grp;
   logic [15:0] m_row [16];
   logic [7:0]  m_cur, m_topc, m_tcode, m_idx;

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_code(input logic [7:0] op, input logic alt, input logic tbl);
      if (alt)                return tbl ? 8'h11 : 8'h12;
      else if (op[7:4] == 4'h1) return 8'h5F;
      else                    return 8'h10;
   endfunction

   task automatic model_reset();
      m_grp = 16'h045B;
      for (int g = 0; g < 16; g++) m_row[g] = 16'hFFFF;
      m_row[0]  = 16'h4FEB;
      m_row[4]  = 16'h0015;
      m_row[10] = 16'hFEFF;
      m_cur = '0; m_topc = '0; m_tcode = '0; m_idx = '0;
   endtask

   // Predict the outcome of an opcode against the current model.
   task automatic predict(input logic [7:0] op, input logic alt, input logic tbl,
                          output logic e_start, output logic e_trap);
      e_start = 1'b0; e_trap = 1'b0;
      m_cur = op;
      if (!m_grp[op[7:4]]) begin
         e_trap = 1'b1; m_topc = 8'hFF; m_tcode = exp_code(8'hFF, alt, tbl);
      end else if (m_row[op[7:4]][op[3:0]]) begin
         e_start = 1'b1; m_idx = op;
      end else begin
         e_trap = 1'b1; m_topc = op; m_tcode = exp_code(op, alt, tbl);
      end
   endtask

   task automatic check_outputs(input string req, input logic e_start, input logic e_trap);
      chk(req, "handler_start", handler_start, e_start);
      chk(req, "trap_valid", trap_valid, e_trap);
      chk(req, "handler_idx", handler_idx, m_idx);
      chk(req, "trap_code", trap_code, m_tcode);
      chk(req, "trap_opcode", trap_opcode, m_topc);
   endtask

   task automatic run_op(input string req, input logic [7:0] op, input logic alt, input logic tbl);
      logic es, et;
      @(negedge clk);
      chk("R3", "idle pulses", {handler_start, trap_valid}, 2'b00);
      op_valid = 1'b1; op_code = op; mode_alt = alt; trap_tbl_present = tbl;
      predict(op, alt, tbl, es, et);
      @(negedge clk);
      op_valid = 1'b0;
      check_outputs(req, es, et);
   endtask

   task automatic cfg_write(input logic sel, input logic [3:0] grp, input logic [15:0] data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_group = grp; cfg_data = data;
      @(negedge clk);
      cfg_we = 1'b0;
      if (sel) m_row[grp] = data; else m_grp[grp] = data[0];
   endtask

   task automatic handler_trap(input logic with_op, input logic [7:0] op, input logic alt, input logic tbl);
      @(negedge clk);
      hdl_trap = 1'b1; mode_alt = alt; trap_tbl_present = tbl;
      op_valid = with_op; op_code = op;
      m_topc = m_cur; m_tcode = exp_code(m_cur, alt, tbl);
      @(negedge clk);
      hdl_trap = 1'b0; op_valid = 1'b0;
      check_outputs("R8", 1'b0, 1'b1);
   endtask

   task automatic finish_handler(input logic pushed);
      @(negedge clk);
      hdl_done = 1'b1; hdl_pushed = pushed;
      @(negedge clk);
      hdl_done = 1'b0; hdl_pushed = 1'b0;
      chk("R9", "sp_dec", sp_dec, !pushed);
      @(negedge clk);
      chk("R9", "sp_dec falls", sp_dec, 1'b0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; bad++;
         $display("FAIL R3 watchdog act=%0d exp=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      model_reset();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: all outputs zero out of reset
      chk("R11", "reset outputs",
          {handler_start, trap_valid, sp_dec, handler_idx, trap_code, trap_opcode}, '0);

      // R1 R2: sweep every opcode against the reset maps, native mode
      for (int i = 0; i < 256; i++) run_op("R1_R2", 8'(i), 1'b0, 1'b0);

      // R5 float trap keeps its opcode; R6 native code
      cfg_write(1'b1, 4'h1, 16'hFFFE);
      run_op("R5", 8'h10, 1'b0, 1'b0);
      run_op("R6", 8'h41, 1'b0, 1'b1);
      // R7 alternate mode codes, including the float group
      run_op("R7", 8'h10, 1'b1, 1'b1);
      run_op("R7", 8'h10, 1'b1, 1'b0);
      run_op("R7", 8'h02, 1'b1, 1'b1);
      run_op("R7", 8'h5C, 1'b1, 1'b0);
      // R4: disabling the float group squashes with a non-float code
      cfg_write(1'b0, 4'h1, 16'h0000);
      run_op("R4", 8'h13, 1'b0, 1'b0);
      run_op("R4", 8'h10, 1'b1, 1'b1);
      // R10: write in the same cycle as an opcode uses the old map
      @(negedge clk);
      begin
         logic es, et;
         cfg_we = 1'b1; cfg_sel = 1'b0; cfg_group = 4'h2; cfg_data = 16'h0001;
         op_valid = 1'b1; op_code = 8'h25; mode_alt = 1'b0;
         predict(8'h25, 1'b0, trap_tbl_present, es, et);
         @(negedge clk);
         cfg_we = 1'b0; op_valid = 1'b0;
         m_grp[2] = 1'b1;
         check_outputs("R10", es, et);
      end
      run_op("R10", 8'h25, 1'b0, 1'b0);
      cfg_write(1'b1, 4'h2, 16'h0020);
      run_op("R10", 8'h25, 1'b0, 1'b0);
      run_op("R10", 8'h24, 1'b0, 1'b0);

      // R8: handler trap alone and against a new opcode
      run_op("R3", 8'h00, 1'b0, 1'b0);
      handler_trap(1'b0, 8'h00, 1'b0, 1'b0);
      run_op("R3", 8'h11, 1'b0, 1'b0);
      handler_trap(1'b1, 8'h00, 1'b1, 1'b0);
      run_op("R11", 8'h00, 1'b0, 1'b0);

      // R9
      finish_handler(1'b0);
      finish_handler(1'b1);

      // Random mix against the model
      cfg_write(1'b0, 4'h1, 16'h0001);
      cfg_write(1'b1, 4'h1, 16'hFFFF);
      for (int n = 0; n < 600; n++) begin
         int unsigned r;
         r = $urandom;
         if (r % 16 == 0)
            cfg_write(1'((r >> 4) & 1), 4'(r >> 5), 16'($urandom));
         else if (r % 16 == 1)
            handler_trap(1'((r >> 4) & 1), 8'($urandom), 1'((r >> 5) & 1), 1'((r >> 6) & 1));
         else if (r % 16 == 2)
            finish_handler(1'((r >> 4) & 1));
         else
            run_op("R3", 8'($urandom), 1'((r >> 4) & 1), 1'((r >> 5) & 1));
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

endmodule